// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two signals of an incremental encoder, A and B, into a 32-bit position value that software can read or preset over a small register bus. A source field selects how the two pins are interpreted. In quadrature mode the block decodes direction from the phase relationship of A and B. In pulse-direction mode A is a step clock and B sets the direction. The up-only and down-only modes count A alone, on its rising edges or on both of its edges.

A programmable maximum position sets the counting range. Counting up past the maximum wraps the position to zero and raises an overflow event. Counting down past zero wraps it to the maximum and raises an underflow event. Each event sets a sticky flag. The flags are masked by an enable register and combined into one interrupt line. Software clears a flag by writing a one to the matching bit of the clear register.

Both pins pass through two-flop synchronizers, and all edge detection runs in the system clock domain. The bus uses word addresses. Read data is registered and appears one clock after the address.

Top module: `qep_counter`

## Requirements
- R1: After reset the position reads 0, the maximum (word 1) reads 0xFFFFFFFF, the flag register (word 5) reads 0 and irq is low.
- R2: In quadrature mode (decoder control word 2, bits 15:14 = 0) every edge of A or B moves the position by one. With (A,B) stepping 00→10→11→01→00 (A leading) the position counts up; the reverse order counts down.
- R3: In quadrature mode a change of both A and B between two synchronized samples is ignored and leaves the position unchanged.
- R4: In pulse-direction mode (source 1) only a rising edge of A counts: up when B is high and down when B is low. Falling edges of A and changes of B do not count.
- R5: In up-count mode (source 2) A counts up on rising edges only when bit 11 of word 2 is 0, and on both edges when it is 1. B is ignored.
- R6: In down-count mode (source 3) A counts down, with the same edge selection as R5. B is ignored.
- R7: Bit 3 of the main control register (word 3) enables counting. While it is 0 the position holds through any pin activity.
- R8: A write to the position register (word 0) is applied only when the written value is not greater than the current maximum; otherwise the position keeps its value.
- R9: A count up from the maximum gives 0 and sets overflow flag bit 6. A count down from 0 gives the maximum and sets underflow flag bit 5.
- R10: Flags are sticky. Writing a one to bit 6 or bit 5 of the clear register (word 6) clears that flag and leaves the other flag unchanged.
- R11: irq, mirrored in flag bit 0, is high one clock after any flag whose enable bit (word 4, bit 6 or 5) is set. It is low while all set flags are masked or after they are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder input A, asynchronous |
| enc_b | input | 1 | Encoder input B, asynchronous |
| bus_addr | input | 3 | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq | output | 1 | Interrupt, high while an enabled flag is set |

## Verification
The bench walks the position across both wrap points. A design that compares against the wrong bound either stops at the maximum or never sets the overflow and underflow flags. It also drives simultaneous changes of A and B; a decoder that does not treat these as illegal counts a phantom step. Over-range preset writes are checked so that a missing bound test shows up as a position above the maximum. The interrupt is checked against masked flags and partial clears, where a wrong mask or an unsticky flag leaves irq in the wrong state.

// File: rtl/qep_pkg.sv
package qep_pkg;
  typedef enum logic [1:0] {
    SRC_QUAD = 2'd0,
    SRC_PDIR = 2'd1,
    SRC_UP   = 2'd2,
    SRC_DOWN = 2'd3
  } src_e;

  localparam int SRC_LSB  = 14;
  localparam int EDGE_BIT = 11;
  localparam int RUN_BIT  = 3;
  localparam int OVF_BIT  = 6;
  localparam int UNF_BIT  = 5;
  localparam int IRQ_BIT  = 0;

  localparam logic [2:0] A_POS = 3'd0;
  localparam logic [2:0] A_MAX = 3'd1;
  localparam logic [2:0] A_DEC = 3'd2;
  localparam logic [2:0] A_CTL = 3'd3;
  localparam logic [2:0] A_IEN = 3'd4;
  localparam logic [2:0] A_FLG = 3'd5;
  localparam logic [2:0] A_CLR = 3'd6;
endpackage

// File: rtl/qep_sync.sv
module qep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic now_o,
  output logic was_o
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      last  <= chain[STAGES-1];
    end
  end

  assign now_o = chain[STAGES-1];
  assign was_o = last;
endmodule

// File: rtl/qep_decode.sv
module qep_decode
  import qep_pkg::*;
(
  input  src_e src,
  input  logic both_edges,
  input  logic a_now,
  input  logic a_was,
  input  logic b_now,
  input  logic b_was,
  output logic step_up,
  output logic step_dn
);
  logic a_rise, a_fall, a_chg, b_chg;

  always_comb begin
    a_rise  = a_now & ~a_was;
    a_fall  = ~a_now & a_was;
    a_chg   = a_now ^ a_was;
    b_chg   = b_now ^ b_was;
    step_up = 1'b0;
    step_dn = 1'b0;
    case (src)
      SRC_QUAD: begin
        // a single-pin change only; both pins moving together is illegal
        if (a_chg ^ b_chg) begin
          if (a_now ^ b_was) step_up = 1'b1;
          else               step_dn = 1'b1;
        end
      end
      SRC_PDIR: begin
        if (a_rise) begin
          if (b_now) step_up = 1'b1;
          else       step_dn = 1'b1;
        end
      end
      SRC_UP:   step_up = a_rise | (both_edges & a_fall);
      default:  step_dn = a_rise | (both_edges & a_fall);
    endcase
  end
endmodule

// File: rtl/qep_poscnt.sv
module qep_poscnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         step_up,
  input  logic         step_dn,
  input  logic         ld_req,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] max_val,
  output logic [W-1:0] cnt_o,
  output logic         ovf_ev,
  output logic         unf_ev
);
  logic [W-1:0] cnt_q;
  logic         ld_ok;
  logic         moving;

  assign ld_ok  = ld_req && (ld_val <= max_val);
  assign moving = run && !ld_ok;
  assign ovf_ev = moving && step_up && (cnt_q == max_val);
  assign unf_ev = moving && step_dn && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (ld_ok) begin
      cnt_q <= ld_val;
    end else if (run && step_up) begin
      cnt_q <= (cnt_q == max_val) ? '0 : cnt_q + 1'b1;
    end else if (run && step_dn) begin
      cnt_q <= (cnt_q == '0) ? max_val : cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  AST_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
    (run && step_up && !ld_req && cnt_q == max_val) |=> (cnt_q == '0)); // R9
  AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (run && step_dn && !step_up && !ld_req && cnt_q == '0) |=> (cnt_q == $past(max_val))); // R9
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
    (!run && !ld_req) |=> $stable(cnt_q)); // R7
  AST_REJECT_BIG: assert property (@(posedge clk) disable iff (rst)
    (ld_req && ld_val > max_val && !step_up && !step_dn) |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/qep_events.sv
module qep_events #(
  parameter int NEV = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NEV-1:0] ev,
  input  logic [NEV-1:0] ien,
  input  logic           clr_stb,
  input  logic [NEV-1:0] clr_bits,
  output logic [NEV-1:0] flags_o,
  output logic           irq_o
);
  logic [NEV-1:0] flags_q;
  logic           irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      for (int i = 0; i < NEV; i++) begin
        if (ev[i])                      flags_q[i] <= 1'b1;
        else if (clr_stb && clr_bits[i]) flags_q[i] <= 1'b0;
      end
      irq_q <= |(flags_q & ien);
    end
  end

  assign flags_o = flags_q;
  assign irq_o   = irq_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flags_q[0] && !(clr_stb && clr_bits[0])) |=> flags_q[0]); // R10
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_stb && clr_bits[0] && !ev[0]) |=> !flags_q[0]); // R10
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (ien == '0) |=> !irq_q); // R11
endmodule

// File: rtl/qep_counter.sv
module qep_counter
  import qep_pkg::*;
#(
  parameter int W      = 32,
  parameter int AW     = 3,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enc_a,
  input  logic          enc_b,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          irq
);
  localparam int NPIN = 2;
  localparam int NEV  = 2;

  logic [NPIN-1:0] pins, pin_now, pin_was;
  logic [W-1:0]    max_q, cnt;
  src_e            src_q;
  logic            both_q, run_q;
  logic [NEV-1:0]  ien_q, flags, ev;
  logic            step_up, step_dn, ovf_ev, unf_ev, irq_w;
  logic [W-1:0]    rd_mux;

  assign pins = {enc_b, enc_a};

  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    qep_sync #(.STAGES(STAGES)) u_sync (
      .clk(clk), .rst(rst), .din(pins[g]),
      .now_o(pin_now[g]), .was_o(pin_was[g])
    );
  end

  qep_decode u_dec (
    .src(src_q), .both_edges(both_q),
    .a_now(pin_now[0]), .a_was(pin_was[0]),
    .b_now(pin_now[1]), .b_was(pin_was[1]),
    .step_up(step_up), .step_dn(step_dn)
  );

  qep_poscnt #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .run(run_q),
    .step_up(step_up), .step_dn(step_dn),
    .ld_req(bus_we && bus_addr == AW'(A_POS)), .ld_val(bus_wdata),
    .max_val(max_q), .cnt_o(cnt), .ovf_ev(ovf_ev), .unf_ev(unf_ev)
  );

  // event bit 1 = overflow, bit 0 = underflow
  assign ev = {ovf_ev, unf_ev};

  qep_events #(.NEV(NEV)) u_evt (
    .clk(clk), .rst(rst), .ev(ev), .ien(ien_q),
    .clr_stb(bus_we && bus_addr == AW'(A_CLR)),
    .clr_bits({bus_wdata[OVF_BIT], bus_wdata[UNF_BIT]}),
    .flags_o(flags), .irq_o(irq_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      max_q  <= '1;
      src_q  <= SRC_QUAD;
      both_q <= 1'b0;
      run_q  <= 1'b0;
      ien_q  <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        AW'(A_MAX): max_q <= bus_wdata;
        AW'(A_DEC): begin
          src_q  <= src_e'(bus_wdata[SRC_LSB +: 2]);
          both_q <= bus_wdata[EDGE_BIT];
        end
        AW'(A_CTL): run_q <= bus_wdata[RUN_BIT];
        AW'(A_IEN): ien_q <= {bus_wdata[OVF_BIT], bus_wdata[UNF_BIT]};
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      AW'(A_POS): rd_mux = cnt;
      AW'(A_MAX): rd_mux = max_q;
      AW'(A_DEC): begin
        rd_mux[SRC_LSB +: 2] = src_q;
        rd_mux[EDGE_BIT]     = both_q;
      end
      AW'(A_CTL): rd_mux[RUN_BIT] = run_q;
      AW'(A_IEN): begin
        rd_mux[OVF_BIT] = ien_q[1];
        rd_mux[UNF_BIT] = ien_q[0];
      end
      AW'(A_FLG): begin
        rd_mux[OVF_BIT] = flags[1];
        rd_mux[UNF_BIT] = flags[0];
        rd_mux[IRQ_BIT] = irq_w;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  assign irq = irq_w;

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (flags == '0) |=> !irq); // R11
endmodule

// File: tb/tb_qep_counter.sv
`timescale 1ns/1ps
module tb_qep_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enc_a = 1'b0, enc_b = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int checks = 0, errors = 0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  qep_counter dut (
    .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic pins(input logic a, input logic b);
    @(negedge clk); enc_a = a; enc_b = b;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [1:0] nxt_up(input logic [1:0] ab);
    case (ab)
      2'b00: return 2'b10;
      2'b10: return 2'b11;
      2'b11: return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] nxt_dn(input logic [1:0] ab);
    case (ab)
      2'b00: return 2'b01;
      2'b01: return 2'b11;
      2'b11: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] epos, emax;
    logic        eovf, eunf;
    logic [1:0]  ab;
    void'($urandom(32'h1D5E));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, r); check("R1 pos", r, 32'd0);
    rd(3'd1, r); check("R1 max", r, 32'hFFFF_FFFF);
    rd(3'd5, r); check("R1 flags", r, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);

    wr(3'd3, 32'h8);
    // R2 quadrature forward and backward
    pins(1,0); pins(1,1); pins(0,1); pins(0,0);
    rd(3'd0, r); check("R2 up x4", r, 32'd4);
    pins(0,1); pins(1,1); pins(1,0); pins(0,0);
    rd(3'd0, r); check("R2 down x4", r, 32'd0);

    // R3 double change ignored
    pins(1,1);
    rd(3'd0, r); check("R3 illegal", r, 32'd0);
    pins(0,0);
    rd(3'd0, r); check("R3 illegal back", r, 32'd0);

    // R9 wrap both ways at the reset maximum
    pins(0,1);
    rd(3'd0, r); check("R9 underflow wrap", r, 32'hFFFF_FFFF);
    pins(0,0);
    rd(3'd0, r); check("R9 overflow wrap", r, 32'd0);
    rd(3'd5, r); check("R9 both flags", r, 32'h60);
    check("R11 masked irq", {31'd0, irq}, 32'd0);

    // R11 enable overflow interrupt, R10 partial clear
    wr(3'd4, 32'h40);
    rd(3'd5, r); check("R11 flag bit0", r, 32'h61);
    check("R11 irq high", {31'd0, irq}, 32'd1);
    wr(3'd6, 32'h40);
    rd(3'd5, r); check("R10 partial clear", r, 32'h20);
    check("R11 irq after clear", {31'd0, irq}, 32'd0);
    wr(3'd6, 32'h20);
    rd(3'd5, r); check("R10 clear all", r, 32'h0);
    wr(3'd4, 32'h0);

    // R8 preset bounds
    wr(3'd1, 32'd9);
    wr(3'd0, 32'd12);
    rd(3'd0, r); check("R8 reject", r, 32'd0);
    wr(3'd0, 32'd9);
    rd(3'd0, r); check("R8 accept", r, 32'd9);
    pins(1,0);
    rd(3'd0, r); check("R9 wrap at max", r, 32'd0);
    rd(3'd5, r); check("R9 ovf flag", r, 32'h40);
    wr(3'd6, 32'h60);

    // R7 disabled counter holds
    wr(3'd3, 32'h0);
    pins(1,1); pins(0,1);
    rd(3'd0, r); check("R7 hold", r, 32'd0);
    wr(3'd3, 32'h8);
    pins(0,0);
    rd(3'd0, r); check("R7 resume", r, 32'd1);

    // R4 pulse-direction
    wr(3'd2, 32'h4000);
    wr(3'd0, 32'd3);
    pins(0,1);
    rd(3'd0, r); check("R4 B change no count", r, 32'd3);
    pins(1,1);
    rd(3'd0, r); check("R4 rise up", r, 32'd4);
    pins(0,1);
    rd(3'd0, r); check("R4 fall no count", r, 32'd4);
    pins(0,0); pins(1,0); pins(0,0);
    rd(3'd0, r); check("R4 rise down", r, 32'd3);

    // R5 up-count
    wr(3'd2, 32'h8000);
    pins(1,0); pins(0,0);
    rd(3'd0, r); check("R5 rising only", r, 32'd4);
    wr(3'd2, 32'h8800);
    pins(1,0); pins(0,0);
    rd(3'd0, r); check("R5 both edges", r, 32'd6);
    pins(0,1); pins(0,0);
    rd(3'd0, r); check("R5 B ignored", r, 32'd6);

    // R6 down-count
    wr(3'd2, 32'hC800);
    pins(1,0); pins(0,0);
    rd(3'd0, r); check("R6 both edges", r, 32'd4);
    wr(3'd2, 32'hC000);
    pins(1,0); pins(0,0);
    pins(0,1); pins(0,0);
    rd(3'd0, r); check("R6 rising only B ignored", r, 32'd3);

    // R2 R3 R9 random quadrature walk with a small range
    wr(3'd2, 32'h0);
    emax = 32'd20;
    wr(3'd1, emax);
    wr(3'd0, 32'd5);
    wr(3'd6, 32'h60);
    epos = 32'd5; eovf = 1'b0; eunf = 1'b0; ab = 2'b00;
    for (int i = 0; i < 300; i++) begin
      int unsigned sel;
      sel = $urandom % 8;
      if (sel < 3) begin
        ab = nxt_up(ab);
        if (epos == emax) begin epos = 0; eovf = 1'b1; end
        else epos = epos + 1;
      end else if (sel < 7) begin
        ab = nxt_dn(ab);
        if (epos == 0) begin epos = emax; eunf = 1'b1; end
        else epos = epos - 1;
      end else begin
        ab = ~ab;
      end
      pins(ab[1], ab[0]);
      if (i % 10 == 9) begin
        rd(3'd0, r); check("R2 R3 R9 random walk", r, epos);
      end
    end
    rd(3'd0, r); check("R9 random final pos", r, epos);
    rd(3'd5, r); check("R10 random flags", r, {25'd0, eovf, eunf, 5'd0});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule